// File: doc/BRIEF.md
# Flag-Setting Integer Add Unit

This block is the 32-bit add unit of a simple processor's execute stage. Each accepted request adds a first register operand to either a second register operand or a sign-extended 16-bit immediate. The two carry variants also add the current carry flag as a carry-in. Every add produces the sum together with a fresh carry flag and a fresh overflow flag. All outputs are registered, so they appear one clock after the request.

The carry flag is the unsigned carry out of the top bit. The overflow flag is signed two's-complement overflow. When the overflow-trap enable is set, an add that overflows raises a one-cycle range exception. On that same edge the unit latches the instruction address of the offending add. A carry out on its own never raises the exception. Hazard handling, the register file and exception vectoring are outside this block.

Top module: `addflag_unit`

## Requirements
- R1: The opcode is 2 bits: 00 register add, 01 register add with carry, 10 immediate add, 11 immediate add with carry. The plain forms (00, 10) ignore `flag_cy_in`, so 1 + 2 gives 3 even with the carry flag set.
- R2: The carry forms (01, 11) add `flag_cy_in` as a carry-in at bit 0. For example, 0x40000000 + 0x3fffffff + 1 gives 0x80000000.
- R3: For opcodes 10 and 11 the second operand is `imm_in` sign-extended from 16 to 32 bits, and `src_b` is ignored. 0xfffe acts as -2 and 0x8000 as -32768.
- R4: `carry_q` is the unsigned carry out of bit 31, counting the carry-in. 0xffffffff + 0 + 1 gives 0 with carry set and overflow clear, and the same holds with the operands swapped.
- R5: `ovf_q` is signed overflow, counting the carry-in. 0x40000000 + 0x40000000 sets overflow only. 0xc0000000 + 0xc0000000 sets carry only. 0xbfffffff + 0xbfffffff sets both. 0xc0000000 + 0xbfffffff + 1 gives 0x80000000 with carry set and overflow clear.
- R6: Every add writes both flags, setting or clearing each one from that add alone. Cycles without a request leave the flags unchanged.
- R7: `range_exc` is raised for an add exactly when that add overflows and `ovf_trap_en` is 1. An add that sets only the carry flag never raises it, and nothing raises it while `ovf_trap_en` is 0.
- R8: `range_exc` is high for one cycle per faulting add. On that add `exc_pc` takes `pc_in`; otherwise `exc_pc` keeps its value.
- R9: `res_valid`, `result`, the flags and `range_exc` take effect on the clock edge that samples `req_valid`. A synchronous `rst` clears `res_valid`, both flags, `range_exc`, `result` and `exc_pc` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An add request is present this cycle |
| op_sel | input | 2 | Operation code (see R1) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm_in | input | 16 | Immediate operand, sign-extended |
| flag_cy_in | input | 1 | Current carry flag, used by carry forms |
| ovf_trap_en | input | 1 | Enables the range exception on overflow |
| pc_in | input | 32 | Address of the requesting instruction |
| res_valid | output | 1 | Result and flags were updated by the last edge |
| result | output | 32 | Registered sum |
| carry_q | output | 1 | Registered carry flag |
| ovf_q | output | 1 | Registered overflow flag |
| range_exc | output | 1 | One-cycle range exception pulse |
| exc_pc | output | 32 | Address of the most recent faulting add |

## Verification
The embedded properties check on every cycle the following:
- an exception implies a registered overflow with the trap enabled;
- `exc_pc` stays stable when no exception is raised;
- the flags hold over idle cycles;
- a request is followed by a valid result;
- any reported overflow comes with a result sign opposite the first operand's.

Only the directed scenarios can show the arithmetic itself. This covers:
- the exact sums;
- carry-in selection per opcode;
- sign extension of the immediate;
- the corner cases where a carry-in creates or cancels an overflow.

// File: rtl/addflag_pkg.sv
package addflag_pkg;

    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;
    localparam int PC_W   = 32;

    typedef enum logic [1:0] {
        OP_ADD_RR  = 2'b00,
        OP_ADDC_RR = 2'b01,
        OP_ADD_RI  = 2'b10,
        OP_ADDC_RI = 2'b11
    } add_op_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] sum;
        logic              cy;
        logic              ov;
        logic              exc;
        logic [PC_W-1:0]   epc;
    } add_state_t;

endpackage

// File: rtl/addflag_opsel.sv
module addflag_opsel #(
    parameter int DW = 32,
    parameter int IW = 16
) (
    input  logic [1:0]    op_sel,
    input  logic [DW-1:0] reg_b,
    input  logic [IW-1:0] imm,
    input  logic          flag_cy,
    output logic [DW-1:0] opnd_b,
    output logic          carry_in
);
    localparam int EXT_W = DW - IW;

    logic use_imm;
    logic use_cy;
    logic [DW-1:0] imm_ext;

    // bit 1 picks the immediate form, bit 0 the carry form
    assign use_imm = op_sel[1];
    assign use_cy  = op_sel[0];

    generate
        if (EXT_W > 0) begin : g_sext
            assign imm_ext = {{EXT_W{imm[IW-1]}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[DW-1:0];
        end
    endgenerate

    always_comb begin
        opnd_b   = use_imm ? imm_ext : reg_b;
        carry_in = use_cy & flag_cy;
    end
endmodule

// File: rtl/addflag_core.sv
module addflag_core #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          carry_in,
    output logic [DW-1:0] sum,
    output logic          carry_out,
    output logic          ovf
);
    logic [DW:0] wide;

    always_comb begin
        wide      = {1'b0, opnd_a} + {1'b0, opnd_b} + {{DW{1'b0}}, carry_in};
        sum       = wide[DW-1:0];
        carry_out = wide[DW];
        // signed overflow: like-signed operands yield an opposite-signed sum
        ovf       = (opnd_a[DW-1] == opnd_b[DW-1]) && (sum[DW-1] != opnd_a[DW-1]);
    end
endmodule

// File: rtl/addflag_unit.sv
module addflag_unit
    import addflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm_in,
    input  logic              flag_cy_in,
    input  logic              ovf_trap_en,
    input  logic [PC_W-1:0]   pc_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] result,
    output logic              carry_q,
    output logic              ovf_q,
    output logic              range_exc,
    output logic [PC_W-1:0]   exc_pc
);
    logic [DATA_W-1:0] opnd_b;
    logic              cin;
    logic [DATA_W-1:0] sum;
    logic              cout;
    logic              ovf;

    add_state_t st_d, st_q;

    addflag_opsel #(.DW(DATA_W), .IW(IMM_W)) u_opsel (
        .op_sel   (op_sel),
        .reg_b    (src_b),
        .imm      (imm_in),
        .flag_cy  (flag_cy_in),
        .opnd_b   (opnd_b),
        .carry_in (cin)
    );

    addflag_core #(.DW(DATA_W)) u_core (
        .opnd_a    (src_a),
        .opnd_b    (opnd_b),
        .carry_in  (cin),
        .sum       (sum),
        .carry_out (cout),
        .ovf       (ovf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        st_d.exc = 1'b0;
        if (req_valid) begin
            st_d.sum = sum;
            st_d.cy  = cout;
            st_d.ov  = ovf;
            if (ovf && ovf_trap_en) begin
                st_d.exc = 1'b1;
                st_d.epc = pc_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_valid = st_q.vld;
    assign result    = st_q.sum;
    assign carry_q   = st_q.cy;
    assign ovf_q     = st_q.ov;
    assign range_exc = st_q.exc;
    assign exc_pc    = st_q.epc;

    p_exc_needs_ovf_r7: assert property (@(posedge clk) disable iff (rst)
        range_exc |-> (ovf_q && res_valid && $past(ovf_trap_en)));

    p_epc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !range_exc |-> $stable(exc_pc));

    p_flags_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable({carry_q, ovf_q}));

    p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    p_ovf_sign_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ovf_q) |-> (result[DATA_W-1] != $past(src_a[DATA_W-1])));

endmodule

// File: tb/tb_addflag_unit.sv
module tb_addflag_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  op_sel;
    logic [31:0] src_a, src_b;
    logic [15:0] imm_in;
    logic        flag_cy_in, ovf_trap_en;
    logic [31:0] pc_in;
    logic        res_valid, carry_q, ovf_q, range_exc;
    logic [31:0] result, exc_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addflag_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .imm_in(imm_in), .flag_cy_in(flag_cy_in),
        .ovf_trap_en(ovf_trap_en), .pc_in(pc_in), .res_valid(res_valid),
        .result(result), .carry_q(carry_q), .ovf_q(ovf_q),
        .range_exc(range_exc), .exc_pc(exc_pc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // one add, checked on the following cycle, then one idle cycle checked
    task automatic run_add(input string tag, input logic [1:0] op,
                           input logic [31:0] a, input logic [31:0] b,
                           input logic [15:0] imm, input logic cy, input logic en,
                           input logic [31:0] pc, input logic [31:0] e_res,
                           input logic e_cy, input logic e_ov, input logic e_exc,
                           input logic [31:0] e_pc);
        @(negedge clk);
        req_valid = 1'b1; op_sel = op; src_a = a; src_b = b; imm_in = imm;
        flag_cy_in = cy; ovf_trap_en = en; pc_in = pc;
        @(negedge clk);
        req_valid = 1'b0; flag_cy_in = ~cy; ovf_trap_en = 1'b1; pc_in = 32'hdead_beef;
        chk({tag, " R9 valid"},  {31'd0, res_valid}, 32'd1);
        chk({tag, " result"},    result, e_res);
        chk({tag, " R4 carry"},  {31'd0, carry_q}, {31'd0, e_cy});
        chk({tag, " R5 ovf"},    {31'd0, ovf_q},   {31'd0, e_ov});
        chk({tag, " R7 exc"},    {31'd0, range_exc}, {31'd0, e_exc});
        chk({tag, " R8 epc"},    exc_pc, e_pc);
        @(negedge clk);
        chk({tag, " R8 pulse"},  {31'd0, range_exc}, 32'd0);
        chk({tag, " R6 hold cy"}, {31'd0, carry_q}, {31'd0, e_cy});
        chk({tag, " R6 hold ov"}, {31'd0, ovf_q},   {31'd0, e_ov});
        chk({tag, " R8 epc hold"}, exc_pc, e_pc);
    endtask

    task automatic t_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk({tag, " R9 valid"}, {31'd0, res_valid}, 32'd0);
        chk({tag, " R9 carry"}, {31'd0, carry_q}, 32'd0);
        chk({tag, " R9 ovf"},   {31'd0, ovf_q}, 32'd0);
        chk({tag, " R9 exc"},   {31'd0, range_exc}, 32'd0);
        chk({tag, " R9 epc"},   exc_pc, 32'd0);
    endtask

    task automatic t_plain_reg;
        run_add("R1 add cy0", 2'b00, 32'd1, 32'd2, 16'h7777, 1'b0, 1'b0, 32'h10, 32'd3, 1'b0, 1'b0, 1'b0, 32'd0);
        run_add("R1 add cy1 ignored", 2'b00, 32'd1, 32'd2, 16'h7777, 1'b1, 1'b0, 32'h14, 32'd3, 1'b0, 1'b0, 1'b0, 32'd0);
        run_add("R4 neg small", 2'b00, 32'hffffffff, 32'hfffffffe, 16'h0, 1'b0, 1'b0, 32'h18, 32'hfffffffd, 1'b1, 1'b0, 1'b0, 32'd0);
        run_add("R5 pos ovf", 2'b00, 32'h40000000, 32'h40000000, 16'h0, 1'b1, 1'b0, 32'h1c, 32'h80000000, 1'b0, 1'b1, 1'b0, 32'd0);
        run_add("R5 neg carry only", 2'b00, 32'hc0000000, 32'hc0000000, 16'h0, 1'b0, 1'b0, 32'h20, 32'h80000000, 1'b1, 1'b0, 1'b0, 32'd0);
        run_add("R5 both", 2'b00, 32'hbfffffff, 32'hbfffffff, 16'h0, 1'b0, 1'b0, 32'h24, 32'h7ffffffe, 1'b1, 1'b1, 1'b0, 32'd0);
        run_add("R6 flags cleared", 2'b00, 32'h40000000, 32'h3fffffff, 16'h0, 1'b0, 1'b0, 32'h28, 32'h7fffffff, 1'b0, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic t_carry_reg;
        run_add("R2 cin makes ovf", 2'b01, 32'h40000000, 32'h3fffffff, 16'h0, 1'b1, 1'b0, 32'h30, 32'h80000000, 1'b0, 1'b1, 1'b0, 32'd0);
        run_add("R2 cin zero", 2'b01, 32'h40000000, 32'h3fffffff, 16'h0, 1'b0, 1'b0, 32'h34, 32'h7fffffff, 1'b0, 1'b0, 1'b0, 32'd0);
        run_add("R4 max+0+c", 2'b01, 32'hffffffff, 32'h0, 16'h0, 1'b1, 1'b0, 32'h38, 32'h0, 1'b1, 1'b0, 1'b0, 32'd0);
        run_add("R4 0+max+c", 2'b01, 32'h0, 32'hffffffff, 16'h0, 1'b1, 1'b0, 32'h3c, 32'h0, 1'b1, 1'b0, 1'b0, 32'd0);
        run_add("R5 cin cancels ovf", 2'b01, 32'hc0000000, 32'hbfffffff, 16'h0, 1'b1, 1'b0, 32'h40, 32'h80000000, 1'b1, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic t_imm;
        run_add("R3 imm -2", 2'b10, 32'hffffffff, 32'h12345678, 16'hfffe, 1'b0, 1'b0, 32'h50, 32'hfffffffd, 1'b1, 1'b0, 1'b0, 32'd0);
        run_add("R3 imm pos", 2'b10, 32'h7fff8000, 32'hffffffff, 16'h7fff, 1'b0, 1'b0, 32'h54, 32'h7fffffff, 1'b0, 1'b0, 1'b0, 32'd0);
        run_add("R3 imm -32768", 2'b10, 32'h80008000, 32'h0, 16'h8000, 1'b0, 1'b0, 32'h58, 32'h80000000, 1'b1, 1'b0, 1'b0, 32'd0);
        run_add("R1 imm cy ignored", 2'b10, 32'd1, 32'h55555555, 16'd2, 1'b1, 1'b0, 32'h5c, 32'd3, 1'b0, 1'b0, 1'b0, 32'd0);
        run_add("R3 imm both", 2'b10, 32'h80007fff, 32'h0, 16'h8000, 1'b0, 1'b0, 32'h60, 32'h7fffffff, 1'b1, 1'b1, 1'b0, 32'd0);
    endtask

    task automatic t_carry_imm;
        run_add("R2 immc 0+ffff+c", 2'b11, 32'h0, 32'h0, 16'hffff, 1'b1, 1'b0, 32'h70, 32'h0, 1'b1, 1'b0, 1'b0, 32'd0);
        run_add("R2 immc cin ovf", 2'b11, 32'h7fff8000, 32'h0, 16'h7fff, 1'b1, 1'b0, 32'h74, 32'h80000000, 1'b0, 1'b1, 1'b0, 32'd0);
        run_add("R5 immc cancel", 2'b11, 32'h80007fff, 32'h0, 16'h8000, 1'b1, 1'b0, 32'h78, 32'h80000000, 1'b1, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic t_trap;
        run_add("R7 ovf traps", 2'b00, 32'h40000000, 32'h40000000, 16'h0, 1'b0, 1'b1, 32'h1000, 32'h80000000, 1'b0, 1'b1, 1'b1, 32'h1000);
        run_add("R7 carry no trap", 2'b00, 32'hffffffff, 32'hfffffffe, 16'h0, 1'b0, 1'b1, 32'h2000, 32'hfffffffd, 1'b1, 1'b0, 1'b0, 32'h1000);
        run_add("R7 disabled", 2'b00, 32'hbfffffff, 32'hbfffffff, 16'h0, 1'b0, 1'b0, 32'h3000, 32'h7ffffffe, 1'b1, 1'b1, 1'b0, 32'h1000);
        run_add("R8 both traps", 2'b00, 32'hbfffffff, 32'hbfffffff, 16'h0, 1'b0, 1'b1, 32'h4000, 32'h7ffffffe, 1'b1, 1'b1, 1'b1, 32'h4000);
        run_add("R7 cin ovf traps", 2'b11, 32'h7fffc000, 32'h0, 16'h3fff, 1'b1, 1'b1, 32'h5000, 32'h80000000, 1'b0, 1'b1, 1'b1, 32'h5000);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; op_sel = 2'b00; src_a = '0; src_b = '0;
        imm_in = '0; flag_cy_in = 1'b0; ovf_trap_en = 1'b0; pc_in = '0;
        t_reset("reset");
        t_plain_reg();
        t_carry_reg();
        t_imm();
        t_carry_imm();
        t_trap();
        t_reset("R9 mid-run reset");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule